// File: doc/BRIEF.md
# Sanitising Table Base Register

This block holds one 64-bit base register that describes where an in-memory table lives and which memory attributes apply to it. Software writes it over a 32-bit or a 64-bit bus. A 32-bit write replaces one half of the register and a 64-bit write replaces the whole register. The new word is first merged with the value already held. It is then cleaned before it is stored: attribute codes the block cannot honour are replaced by supported ones, and bits with no meaning are cleared.

The `PENDING` parameter selects which table the register describes, and so which set of bits is cleared. Zero selects the property-table layout and one selects the pending-table layout. While the `lock_i` input is high, the stored value is frozen. Reads have no handshake: the read port returns a byte-aligned slice of the stored value.

The write side is a valid/ready stream. `wr_ready` is held high, so each beat with `wr_valid` high is accepted on that clock edge and takes effect at the same edge. The upstream never has to hold data back. A beat accepted while the register is locked is consumed and discarded.

Top module: `tbr_base_reg`

## Requirements
- R1: After reset the stored value is all zeros, so a full read (address 0, length 8) returns 0.
- R2: An accepted beat with `wr_wide`=1 replaces all 64 bits before cleaning. The result is visible on the read port after the accepting clock edge.
- R3: An accepted beat with `wr_wide`=0 takes `wr_data[31:0]`. It replaces bits 63:32 when `wr_hi`=1 and bits 31:0 when `wr_hi`=0. The other half keeps its value, and the merge happens before cleaning.
- R4: The shareability field at bits 11:10 is stored as 1 when the merged value holds 2. Values 0, 1 and 3 are stored unchanged.
- R5: The inner cache field at bits 9:7 is stored as 7 when the merged value holds 0 or 1. Values 2 to 7 are stored unchanged.
- R6: The outer cache field at bits 58:56 keeps the values 0 and 1. Any other value is stored as 1.
- R7: Bits are cleared according to the variant. With `PENDING`=0 the cleared bits are 63:59, 55:48 and 6:5. With `PENDING`=1 the cleared bits are 63, 61:59, 55:48, 15:12 and 6:0, and bit 62 is kept.
- R8: While `lock_i` is high, accepted beats leave the stored value unchanged.
- R9: `rd_data` equals the stored value shifted right by `rd_addr` bytes, then masked to its low `rd_len` bytes. A length of 8 or more gives no masking, and a length of 0 gives 0.
- R10: `wr_ready` is high whenever reset is released, so one beat can be accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Freezes the stored value while high |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat can be taken (held high out of reset) |
| wr_wide | input | 1 | 1: 64-bit write, 0: 32-bit write |
| wr_hi | input | 1 | For 32-bit writes, selects the upper half |
| wr_data | input | 64 | Write data; 32-bit writes use bits 31:0 |
| rd_addr | input | 3 | Byte offset of the read |
| rd_len | input | 4 | Read length in bytes |
| rd_data | output | 64 | Byte-sliced read data |

## Verification
The properties assume that `lock_i`, `wr_wide` and `wr_hi` are steady whenever `wr_valid` is sampled. They also assume that a beat is judged only by the value stored one edge later. The stimulus changes every input only on the falling edge and holds it through the following rising edge. Read checks use only the combinational read port, sampled at least one time unit after a falling edge, so the stored value is settled. The checks on the half-write keep-out rely on the register never holding an uncleaned upper half. The bench keeps that true, because every route into the upper half passes through the cleaner.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int unsigned TBR_W   = 64;
  localparam int unsigned SH_LSB  = 10;
  localparam int unsigned IC_LSB  = 7;
  localparam int unsigned OC_LSB  = 56;
  localparam logic [1:0] SH_OUTER = 2'd2;
  localparam logic [1:0] SH_INNER = 2'd1;
  localparam logic [2:0] C_DEV    = 3'd0;
  localparam logic [2:0] C_NC     = 3'd1;
  localparam logic [2:0] C_RAWB   = 3'd7;
  localparam logic [2:0] C_SAME   = 3'd0;

  function automatic logic [TBR_W-1:0] span(input int unsigned hi, input int unsigned lo);
    logic [TBR_W-1:0] m;
    m = '0;
    for (int i = 0; i < TBR_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tbr_merge.sv
module tbr_merge
  import tbr_pkg::*;
#(
  parameter int unsigned W = TBR_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] wdata,
  input  logic         wide,
  input  logic         hi,
  output logic [W-1:0] merged
);
  localparam int unsigned HALF = W / 2;

  always_comb begin
    merged = cur;
    if (wide) merged = wdata;
    else if (hi) merged[W-1:HALF] = wdata[HALF-1:0];
    else merged[HALF-1:0] = wdata[HALF-1:0];
  end
endmodule

// File: rtl/tbr_sanitise.sv
module tbr_sanitise
  import tbr_pkg::*;
#(
  parameter bit PENDING = 1'b0
) (
  input  logic [TBR_W-1:0] raw,
  output logic [TBR_W-1:0] clean
);
  localparam logic [TBR_W-1:0] COMMON_RES = span(51, 48);
  logic [TBR_W-1:0] res_mask;
  logic [TBR_W-1:0] remapped;
  logic [1:0] sh;
  logic [2:0] ic, oc;

  generate
    if (PENDING) begin : g_pend
      assign res_mask = COMMON_RES | span(63, 63) | span(61, 59) | span(55, 52)
                      | span(15, 12) | span(6, 0);
    end else begin : g_prop
      assign res_mask = COMMON_RES | span(63, 59) | span(55, 52) | span(6, 5);
    end
  endgenerate

  always_comb begin
    sh = raw[SH_LSB +: 2];
    ic = raw[IC_LSB +: 3];
    oc = raw[OC_LSB +: 3];
    if (sh == SH_OUTER) sh = SH_INNER;
    if (ic == C_DEV || ic == C_NC) ic = C_RAWB;
    if (oc != C_SAME && oc != C_NC) oc = C_NC;
    remapped = raw;
    remapped[SH_LSB +: 2] = sh;
    remapped[IC_LSB +: 3] = ic;
    remapped[OC_LSB +: 3] = oc;
    clean = remapped & ~res_mask;
  end
endmodule

// File: rtl/tbr_slice.sv
module tbr_slice
  import tbr_pkg::*;
(
  input  logic [TBR_W-1:0] value,
  input  logic [2:0]       addr,
  input  logic [3:0]       len,
  output logic [TBR_W-1:0] data
);
  logic [6:0]       nbits;
  logic [TBR_W-1:0] mask;

  always_comb begin
    nbits = {len, 3'b000};
    if (len >= 4'd8) mask = '1;
    else mask = (64'd1 << nbits) - 64'd1;
    data = (value >> {addr, 3'b000}) & mask;
  end
endmodule

// File: rtl/tbr_base_reg.sv
module tbr_base_reg
  import tbr_pkg::*;
#(
  parameter bit PENDING = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_wide,
  input  logic             wr_hi,
  input  logic [TBR_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  input  logic [3:0]       rd_len,
  output logic [TBR_W-1:0] rd_data
);
  logic [TBR_W-1:0] store_q;
  logic [TBR_W-1:0] merged;
  logic [TBR_W-1:0] cleaned;

  assign wr_ready = 1'b1;

  tbr_merge #(.W(TBR_W)) u_merge (
    .cur(store_q), .wdata(wr_data), .wide(wr_wide), .hi(wr_hi), .merged(merged)
  );

  tbr_sanitise #(.PENDING(PENDING)) u_clean (.raw(merged), .clean(cleaned));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else if (wr_valid && wr_ready && !lock_i) store_q <= cleaned;
  end

  tbr_slice u_slice (.value(store_q), .addr(rd_addr), .len(rd_len), .data(rd_data));
endmodule

// File: rtl/tbr_base_reg_chk.sv
module tbr_base_reg_chk
  import tbr_pkg::*;
#(
  parameter bit PENDING = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_i,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_wide,
  input logic             wr_hi,
  input logic [TBR_W-1:0] store_q,
  input logic [2:0]       rd_addr,
  input logic [3:0]       rd_len,
  input logic [TBR_W-1:0] rd_data
);
  localparam logic [TBR_W-1:0] RES = PENDING ?
    (span(63, 63) | span(61, 59) | span(55, 48) | span(15, 12) | span(6, 0)) :
    (span(63, 59) | span(55, 48) | span(6, 5));
  logic take;
  assign take = wr_valid && wr_ready && !lock_i;

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && lock_i) |=> $stable(store_q));
  p_half_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_wide && !wr_hi) |=> (store_q[63:32] == $past(store_q[63:32])));
  p_share_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (store_q[SH_LSB +: 2] != SH_OUTER));
  p_inner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (store_q[IC_LSB +: 3] > C_NC));
  p_outer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (store_q[OC_LSB +: 3] <= C_NC));
  p_res_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((store_q & RES) == '0));
  p_rd_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_len == 4'd0) |-> (rd_data == '0));
  p_rd_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_len == 4'd8 && rd_addr == 3'd0) |-> (rd_data == store_q));
endmodule

bind tbr_base_reg tbr_base_reg_chk #(.PENDING(PENDING)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_wide(wr_wide), .wr_hi(wr_hi), .store_q(store_q),
  .rd_addr(rd_addr), .rd_len(rd_len), .rd_data(rd_data)
);

// File: tb/test_tbr_base_reg.sv
`timescale 1ns/1ps
module test_tbr_base_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_i = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_wide = 1'b0;
  logic        wr_hi = 1'b0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [3:0]  rd_len = 4'd8;
  logic        rdy_a, rdy_b;
  logic [63:0] rd_a, rd_b;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tbr_base_reg #(.PENDING(1'b0)) i_tbr_base_reg (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .wr_valid(wr_valid), .wr_ready(rdy_a),
    .wr_wide(wr_wide), .wr_hi(wr_hi), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_len(rd_len), .rd_data(rd_a));
  tbr_base_reg #(.PENDING(1'b1)) i_tbr_base_reg_pend (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .wr_valid(wr_valid), .wr_ready(rdy_b),
    .wr_wide(wr_wide), .wr_hi(wr_hi), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_len(rd_len), .rd_data(rd_b));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input bit wide, input bit hi, input logic [63:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_wide = wide; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
  endtask

  task automatic both(input string req, input logic [63:0] ea, input logic [63:0] eb);
    rd_addr = 3'd0; rd_len = 4'd8; #0.5;
    check({req, " prop"}, rd_a, ea);
    check({req, " pend"}, rd_b, eb);
  endtask

  task automatic t_reset();
    both("R1 reset", 64'h0, 64'h0);
    check("R10 ready", {62'd0, rdy_a, rdy_b}, 64'h3);
  endtask

  task automatic t_all_ones();
    wr(1'b1, 1'b0, '1);
    both("R7 R2 all ones", 64'h0100FFFF_FFFFFF9F, 64'h4100FFFF_FFFF0F80);
  endtask

  task automatic t_remap();
    wr(1'b1, 1'b0, 64'h06001234_56780880);
    both("R4 R5 R6 remap", 64'h01001234_56780780, 64'h01001234_56780780);
    wr(1'b1, 1'b0, 64'h0);
    both("R5 device zero", 64'h380, 64'h380);
    wr(1'b1, 1'b0, 64'h00000000_00000E80);
    both("R4 R5 R6 passthrough", 64'hE80, 64'hE80);
  endtask

  task automatic t_halves();
    wr(1'b1, 1'b0, 64'h00001234_56780780);
    wr(1'b0, 1'b1, 64'hDEAD0000_0000ABCD);
    both("R3 upper half", 64'h0000ABCD_56780780, 64'h0000ABCD_56780780);
    wr(1'b0, 1'b0, 64'h77770000_99990C00);
    both("R3 lower half", 64'h0000ABCD_99990F80, 64'h0000ABCD_99990F80);
    wr(1'b0, 1'b1, 64'h00000000_FFFFFFFF);
    both("R3 R7 upper ones", 64'h0100FFFF_99990F80, 64'h4100FFFF_99990F80);
  endtask

  task automatic t_lock();
    @(negedge clk); lock_i = 1'b1;
    wr(1'b1, 1'b0, 64'h0);
    wr(1'b0, 1'b0, 64'h12345678);
    both("R8 locked", 64'h0100FFFF_99990F80, 64'h4100FFFF_99990F80);
    @(negedge clk); lock_i = 1'b0;
    #1;
  endtask

  task automatic t_reads();
    rd_addr = 3'd2; rd_len = 4'd2; #0.5; check("R9 a2 l2", rd_a, 64'h9999);
    rd_addr = 3'd4; rd_len = 4'd4; #0.5; check("R9 a4 l4", rd_b, 64'h4100FFFF);
    rd_addr = 3'd7; rd_len = 4'd1; #0.5; check("R9 a7 l1", rd_a, 64'h01);
    rd_addr = 3'd0; rd_len = 4'd0; #0.5; check("R9 len0", rd_a, 64'h0);
    rd_addr = 3'd5; rd_len = 4'd8; #0.5; check("R9 a5 l8", rd_a, 64'h000100FF);
    rd_addr = 3'd1; rd_len = 4'd15; #0.5; check("R9 len15", rd_b, 64'h004100FF_FF99990F);
  endtask

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_all_ones();
    t_remap();
    t_halves();
    t_lock();
    t_reads();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired got=hang exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule